// File: doc/BRIEF.md
# Multi-drop SPI register target

This block is the serial front end of one hashing chip on an SPI bus that up to thirty-two chips share. Every chip on the bus sees every transaction. Each chip compares the identifier in the transaction header with its own strapped identifier, and only the chip whose identifier matches takes part. The link runs in mode 0 with 8-bit frames, most significant bit first. The block samples the serial pins with its own system clock, so the system clock must run several times faster than the serial clock.

A transaction opens with a four-byte header, in this order:

1. chip identifier
2. address byte, where the top bit is the read flag and the lower seven bits are the register address
3. low half of a 16-bit byte count
4. high half of the byte count

After the header, a write delivers each data byte to a generic internal register port. A read returns data in the byte slots that follow the header, while the master clocks filler bytes. Addresses 0x00 (a four-byte identity pattern) and 0x01 (a four-byte status word carrying the core count) are served inside the block. All other addresses go to the internal port, one byte at a time, with a byte index that counts up from zero.

Top module: `spi_drop_target`

## Requirements
- R1: The header bytes arrive in the order identifier, address, count low, count high. The byte count is the 16-bit value {high, low}, so a count whose high byte is nonzero still opens a data phase.
- R2: A set bit 7 in the address byte selects a read. A clear bit 7 selects a write. Bits 6:0 form the register address. The read and write strobes never assert together.
- R3: The chip takes part only when the identifier byte equals {3'b000, chip_id}. Otherwise the chip never enables its MISO driver, so a pulled-up line reads 0xFF, and it raises no port strobes.
- R4: A read of address 0x00 returns byte k as 0x44, 0x8A, 0xAC, 0xB1 for k mod 4 = 0, 1, 2, 3.
- R5: A read of address 0x01 returns the CORES parameter in byte positions with k mod 4 = 2, and 0x00 in all other positions.
- R6: A read of any address above 0x01 pulses reg_rd_en once for each returned byte. The pulse carries reg_addr and reg_idx = k, and the byte sent is the reg_rd_data value sampled in that cycle.
- R7: A write to an address above 0x01 pulses reg_wr_en once for each received data byte, carrying reg_addr, reg_idx = k and the byte. Bytes beyond the count are dropped.
- R8: Writes to 0x00 or 0x01 produce no reg_wr_en pulse and leave both registers unchanged.
- R9: spi_miso_oe is low during the header and after the counted bytes. A zero count gives no data phase. Data bits change after falling SCLK edges, ready for the next rising edge.
- R10: Raising spi_cs_n at any point ends the transaction. A partial byte is discarded, and the next transaction starts a fresh header.
- R11: During and after reset, spi_miso_oe, reg_wr_en and reg_rd_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id | input | 5 | Strapped identifier of this chip |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select, shared by all chips |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | MISO driver enable, low means released |
| reg_addr | output | 7 | Register address of the current transaction |
| reg_idx | output | 16 | Byte index within the burst |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | 8 | Read data, sampled in the strobe cycle |

## Verification
The hardest case to reach is the handover from header to first data byte. That byte must be fetched and presented between the last header rising edge and the next one, with no falling edge in between that shifts it early. A related case is a chip select that rises partway through a byte. The bench drives a bit-level mode-0 master that can stop after any number of bits. It reads every slot through a modelled pull-up, including the header slots and one slot past the count. It also runs a burst whose count has only its high byte set.

// File: rtl/spi_drop_pkg.sv
package spi_drop_pkg;

  localparam int ID_W = 5;

  typedef enum logic [1:0] {PH_HDR, PH_DATA, PH_SKIP} phase_t;

  localparam logic [6:0] ADDR_SIG  = 7'h00;
  localparam logic [6:0] ADDR_STAT = 7'h01;

  // Identity pattern, repeating every four bytes.
  function automatic logic [7:0] sig_byte(input logic [1:0] k);
    case (k)
      2'd0:    return 8'h44;
      2'd1:    return 8'h8A;
      2'd2:    return 8'hAC;
      default: return 8'hB1;
    endcase
  endfunction

  // Status word: core count in byte position 2.
  function automatic logic [7:0] stat_byte(input logic [1:0] k, input logic [7:0] cores);
    return (k == 2'd2) ? cores : 8'h00;
  endfunction

  function automatic logic id_hit(input logic [7:0] id, input logic [ID_W-1:0] strap);
    return id == {{(8-ID_W){1'b0}}, strap};
  endfunction

  function automatic logic is_local(input logic [6:0] a);
    return a <= ADDR_STAT;
  endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_on,
  output logic cs_end,
  output logic mosi_q
);
  logic [STAGES:0] sclk_p, cs_p;
  logic [STAGES-1:0] mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[STAGES-1:0], sclk};
      cs_p   <= {cs_p[STAGES-1:0], cs_n};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
    end
  end

  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_p[STAGES];
  assign cs_on     = ~cs_p[STAGES-1];
  assign cs_end    = cs_p[STAGES-1] & ~cs_p[STAGES];
  assign mosi_q    = mosi_p[STAGES-1];

endmodule

// File: rtl/spi_byte_io.sv
module spi_byte_io #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_on,
  input  logic            rise,
  input  logic            fall,
  input  logic            mosi_q,
  input  logic            load,
  input  logic [BITS-1:0] load_byte,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte,
  output logic            tx_bit
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0]   bit_cnt;
  logic [BITS-1:0] rx_sr, tx_sr;

  assign byte_done = cs_on && rise && (bit_cnt == LAST);
  assign rx_byte   = {rx_sr[BITS-2:0], mosi_q};
  assign tx_bit    = tx_sr[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '1;
    end else begin
      if (!cs_on) begin
        bit_cnt <= '0;
      end else if (rise) begin
        bit_cnt <= bit_cnt + CW'(1);
        rx_sr   <= rx_byte;
      end
      // A freshly loaded byte holds its MSB through the falling edge that
      // precedes the byte's first rising edge.
      if (load)
        tx_sr <= load_byte;
      else if (cs_on && fall && bit_cnt != '0)
        tx_sr <= {tx_sr[BITS-2:0], 1'b1};
    end
  end

  AST_BIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (bit_cnt == '0)) else $error("bit counter did not wrap"); // R9

endmodule

// File: rtl/spi_drop_target.sv
module spi_drop_target
  import spi_drop_pkg::*;
#(
  parameter logic [7:0] CORES = 8'd8,
  parameter int         CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  chip_id,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  output logic [6:0]       reg_addr,
  output logic [CNT_W-1:0] reg_idx,
  output logic             reg_wr_en,
  output logic [7:0]       reg_wr_data,
  output logic             reg_rd_en,
  input  logic [7:0]       reg_rd_data
);
  logic sclk_rise, sclk_fall, cs_on, cs_end, mosi_q;
  logic byte_done, tx_bit;
  logic [7:0] rx_byte, rd_byte;

  phase_t           phase;
  logic [1:0]       hdr_pos;
  logic [7:0]       hdr_id, cnt_lo;
  logic [6:0]       cur_addr;
  logic             cur_rd, oe_q;
  logic [CNT_W-1:0] remain, idx, rem_next, load_idx, hdr_count;
  logic             hdr_last, hit, go_data, data_byte, rd_load, at_local;

  spi_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_on(cs_on), .cs_end(cs_end),
    .mosi_q(mosi_q)
  );

  spi_byte_io #(.BITS(8)) u_io (
    .clk(clk), .rst_n(rst_n), .cs_on(cs_on), .rise(sclk_rise), .fall(sclk_fall),
    .mosi_q(mosi_q), .load(rd_load), .load_byte(rd_byte),
    .byte_done(byte_done), .rx_byte(rx_byte), .tx_bit(tx_bit)
  );

  // Named internal events
  assign hdr_count = CNT_W'({rx_byte, cnt_lo});
  assign hdr_last  = byte_done && phase == PH_HDR && hdr_pos == 2'd3;
  assign hit       = id_hit(hdr_id, chip_id);
  assign go_data   = hdr_last && hit && hdr_count != '0;
  assign data_byte = byte_done && phase == PH_DATA;
  assign rem_next  = remain - CNT_W'(1);
  assign rd_load   = cur_rd && (go_data || (data_byte && rem_next != '0));
  assign load_idx  = go_data ? '0 : idx + CNT_W'(1);
  assign at_local  = is_local(cur_addr);

  always_comb begin
    if (cur_addr == ADDR_SIG)       rd_byte = sig_byte(load_idx[1:0]);
    else if (cur_addr == ADDR_STAT) rd_byte = stat_byte(load_idx[1:0], CORES);
    else                            rd_byte = reg_rd_data;
  end

  assign reg_addr    = cur_addr;
  assign reg_idx     = rd_load ? load_idx : idx;
  assign reg_wr_data = rx_byte;
  assign reg_wr_en   = data_byte && !cur_rd && !at_local;
  assign reg_rd_en   = rd_load && !at_local;
  assign spi_miso    = tx_bit;
  assign spi_miso_oe = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HDR;
      hdr_pos  <= '0;
      hdr_id   <= '0;
      cnt_lo   <= '0;
      cur_addr <= '0;
      cur_rd   <= 1'b0;
      remain   <= '0;
      idx      <= '0;
      oe_q     <= 1'b0;
    end else if (!cs_on) begin
      phase   <= PH_HDR;
      hdr_pos <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (rd_load) oe_q <= 1'b1;
      if (byte_done) begin
        unique case (phase)
          PH_HDR: begin
            hdr_pos <= hdr_pos + 2'd1;
            case (hdr_pos)
              2'd0: hdr_id <= rx_byte;
              2'd1: begin
                cur_addr <= rx_byte[6:0];
                cur_rd   <= rx_byte[7];
              end
              2'd2: cnt_lo <= rx_byte;
              default: begin
                phase  <= go_data ? PH_DATA : PH_SKIP;
                remain <= hdr_count;
                idx    <= '0;
              end
            endcase
          end
          PH_DATA: begin
            remain <= rem_next;
            idx    <= idx + CNT_W'(1);
            if (rem_next == '0) begin
              phase <= PH_SKIP;
              oe_q  <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en)) else $error("read and write strobe together"); // R2
  AST_OE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe |-> id_hit(hdr_id, chip_id)) else $error("driving MISO unselected"); // R3
  AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (remain != '0)) else $error("write past byte count"); // R7
  AST_WR_NOT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_addr > ADDR_STAT)) else $error("write to read-only register"); // R8
  AST_HDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HDR) |-> (!spi_miso_oe && !reg_wr_en)) else $error("activity in header"); // R9
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> (phase == PH_HDR && hdr_pos == 2'd0 && !spi_miso_oe)) else $error("abort failed"); // R10

endmodule

// File: tb/tb_spi_drop_target.sv
module tb_spi_drop_target;
  localparam int HALF = 8;
  localparam logic [4:0] STRAP = 5'h13;
  localparam logic [7:0] NCORE = 8'd8;
  localparam int NV = 11;
  // {chip id, address byte, byte count}
  localparam logic [31:0] VEC [NV] = '{
    {8'h13, 8'h80, 16'h0004},  // R4 signature
    {8'h13, 8'h00, 16'h0002},  // R8 write to signature
    {8'h13, 8'h80, 16'h0006},  // R4 wrap
    {8'h13, 8'h81, 16'h0004},  // R5 status
    {8'h13, 8'hA5, 16'h0003},  // R6 port read
    {8'h13, 8'h30, 16'h0003},  // R7 port write
    {8'h12, 8'h80, 16'h0004},  // R3 other chip
    {8'h33, 8'h80, 16'h0004},  // R3 upper id bits
    {8'h13, 8'h80, 16'h0000},  // R9 zero count
    {8'h12, 8'h30, 16'h0002},  // R3 write to other chip
    {8'h13, 8'hA6, 16'h0100}   // R1 high count byte
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, wr_en, rd_en;
  logic [6:0] raddr;
  logic [15:0] ridx;
  logic [7:0] wdata, rdata;
  wire line = miso_oe ? miso : 1'b1;

  int checks = 0, fails = 0, cyc = 0;
  int wr_n = 0, rd_n = 0;
  logic [6:0] wl_addr [16];
  logic [15:0] wl_idx [16];
  logic [7:0] wl_data [16];
  logic [7:0] got [12];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] ext(input logic [6:0] a, input logic [15:0] k);
    return {a[3:0], k[3:0]} ^ 8'h3C;
  endfunction
  assign rdata = ext(raddr, ridx);

  spi_drop_target #(.CORES(NCORE), .CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .chip_id(STRAP), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe), .reg_addr(raddr),
    .reg_idx(ridx), .reg_wr_en(wr_en), .reg_wr_data(wdata), .reg_rd_en(rd_en),
    .reg_rd_data(rdata)
  );

  always @(negedge clk) if (rst_n) begin
    if (wr_en && wr_n < 16) begin
      wl_addr[wr_n] = raddr; wl_idx[wr_n] = ridx; wl_data[wr_n] = wdata;
    end
    if (wr_en) wr_n++;
    if (rd_en) rd_n++;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'hFF;
    for (int b = 7; b > 7 - nb; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = line;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_low;
    @(negedge clk); cs_n = 1'b0; repeat (HALF) @(negedge clk);
  endtask
  task automatic cs_high;
    repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (4 * HALF) @(negedge clk);
  endtask

  // Full transaction: header then n data bytes; got[0..3] header slots.
  task automatic xact(input logic [7:0] id, input logic [7:0] ab, input logic [15:0] cnt, input int n);
    logic [7:0] r;
    wr_n = 0; rd_n = 0;
    cs_low();
    xbits(id, 8, r);        got[0] = r;
    xbits(ab, 8, r);        got[1] = r;
    xbits(cnt[7:0], 8, r);  got[2] = r;
    xbits(cnt[15:8], 8, r); got[3] = r;
    for (int k = 0; k < n; k++) begin
      xbits(8'hC0 + 8'(k), 8, r);
      got[4 + k] = r;
    end
    cs_high();
  endtask

  function automatic logic [7:0] model(input logic sel, input logic [7:0] ab,
                                       input logic [15:0] cnt, input int k);
    logic [7:0] sig [4];
    sig = '{8'h44, 8'h8A, 8'hAC, 8'hB1};
    if (!sel || !ab[7] || k >= int'(cnt)) return 8'hFF;
    if (ab[6:0] == 7'd0) return sig[k % 4];
    if (ab[6:0] == 7'd1) return (k % 4 == 2) ? NCORE : 8'h00;
    return ext(ab[6:0], 16'(k));
  endfunction

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc == 150000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!miso_oe && !wr_en && !rd_en, "R11 outputs idle in reset", {miso_oe, wr_en, rd_en}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!miso_oe && !wr_en && !rd_en, "R11 outputs idle after reset", {miso_oe, wr_en, rd_en}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] id, ab;
      logic [15:0] cnt;
      logic sel;
      int n, exp_wr, exp_rd;
      {id, ab, cnt} = VEC[v];
      n = (int'(cnt) + 1 > 7) ? 7 : int'(cnt) + 1;
      sel = (id == {3'b000, STRAP});
      xact(id, ab, cnt, n);
      chk(got[0] == 8'hFF && got[1] == 8'hFF && got[2] == 8'hFF && got[3] == 8'hFF,
          "R9 header slots released", got[3], 8'hFF);
      for (int k = 0; k < n; k++) begin
        logic [7:0] e;
        string tag;
        e = model(sel, ab, cnt, k);
        if (!sel) tag = "R3 unselected";
        else if (!ab[7] || k >= int'(cnt)) tag = "R9 released slot";
        else if (ab[6:0] == 7'd0) tag = "R4 signature";
        else if (ab[6:0] == 7'd1) tag = "R5 status";
        else tag = "R6 port read";
        chk(got[4 + k] == e, tag, got[4 + k], e);
      end
      exp_wr = (sel && !ab[7] && ab[6:0] > 7'd1) ? int'(cnt) : 0;
      exp_rd = (sel && ab[7] && ab[6:0] > 7'd1) ? ((int'(cnt) < n + 1) ? int'(cnt) : n + 1) : 0;
      chk(wr_n == exp_wr, "R7 R8 write strobe count", wr_n, exp_wr);
      chk(rd_n == exp_rd, "R6 R1 read strobe count", rd_n, exp_rd);
      for (int k = 0; k < exp_wr && k < 16; k++)
        chk(wl_addr[k] == ab[6:0] && wl_idx[k] == 16'(k) && wl_data[k] == 8'hC0 + 8'(k),
            "R7 write entry", wl_data[k], 8'hC0 + 8'(k));
    end

    // R10: abort mid data byte, one full byte committed, partial byte dropped
    begin
      logic [7:0] r;
      wr_n = 0;
      cs_low();
      xbits(8'h13, 8, r); xbits(8'h30, 8, r); xbits(8'h04, 8, r); xbits(8'h00, 8, r);
      xbits(8'hC0, 8, r); xbits(8'h5A, 3, r);
      cs_high();
      chk(wr_n == 1, "R10 partial byte discarded", wr_n, 1);
      chk(wl_data[0] == 8'hC0 && wl_idx[0] == 16'd0, "R10 committed byte", wl_data[0], 8'hC0);
      // abort inside the header, then a fresh transaction
      cs_low();
      xbits(8'h13, 8, r); xbits(8'h81, 8, r);
      cs_high();
      xact(8'h13, 8'h80, 16'h0002, 2);
      chk(got[4] == 8'h44 && got[5] == 8'h8A, "R10 fresh header after abort", got[4], 8'h44);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule